// File: doc/BRIEF.md
# Video-Timing Status Register Readback

This block is the read side of a small group of processor-visible status registers. Each status byte holds only a handful of live flags: a sticky NMI flag, a sticky IRQ flag, vertical and horizontal blanking decoded from the raster counters, a controller-poll busy flag, a chip version code and the controller port 2 serial lines. Every bit that carries no flag is filled from the open-bus register. That register holds the last byte that crossed the data bus, whether the byte was read or written.

A read is combinational. `rdData` is valid in the same cycle that `rdEn` is high, and any side effect of the read takes place at the closing clock edge. Reading the NMI status byte clears the NMI flag, and reading the IRQ status byte clears the IRQ flag. A set event arriving in the same cycle wins over the clear.

The block also holds one writable I/O port byte, which reads back unchanged. When a write moves bit 7 of that byte from 1 to 0, the block raises `latchPulse` for one cycle so that the raster counters can be latched elsewhere. The design contains no interrupt generation logic.

Top module: `video_status_regs`

## Requirements
- R1: A read of address 0x4210 returns the NMI flag in bit 7, open-bus bits 6..4 in bits 6..4, and `version` in bits 3..0.
- R2: A pulse on `nmiEvent` sets the NMI flag. A read of 0x4210 clears the flag at the closing edge. When `nmiEvent` and that read occur in the same cycle, the flag stays set, and the read returns the flag's value from before that cycle.
- R3: A read of 0x4211 returns the IRQ flag in bit 7 and open-bus bits 6..0 in bits 6..0. The IRQ flag is set by `irqEvent` and cleared by this read, with the same priority rule as R2.
- R4: A read of 0x4212 has bit 7 set exactly when `vCount` >= `activeLines`.
- R5: A read of 0x4212 has bit 6 set exactly when `hCount` <= 2 or `hCount` >= 1096.
- R6: A read of 0x4212 carries `pollBusy` in bit 0 and open-bus bits 5..1 in bits 5..1.
- R7: A write to 0x4201 stores the byte, and a read of 0x4213 returns it unchanged. This port resets to 0xFF.
- R8: `latchPulse` is high for exactly the one cycle that follows a write to 0x4201 in which the stored bit 7 was 1 and the written bit 7 is 0. It is low in every other cycle.
- R9: A read of 0x4017 returns open-bus bits 7..5, ones in bits 4..2, and `pad2Data` in bits 1..0.
- R10: The open-bus byte takes the written data after every write and the returned byte after every read. A read of any address other than 0x4210, 0x4211, 0x4212, 0x4213 or 0x4017 returns the open-bus byte. If `rdEn` and `wrEn` are both high, the cycle is treated as a write.
- R11: After reset the open-bus byte is 0x00, both interrupt flags are clear and `latchPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Register address |
| rdEn | input | 1 | Read strobe for this cycle |
| wrEn | input | 1 | Write strobe for this cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| hCount | input | 11 | Horizontal raster counter |
| vCount | input | 9 | Vertical raster counter |
| activeLines | input | 9 | Number of active display lines |
| nmiEvent | input | 1 | Sets the NMI flag |
| irqEvent | input | 1 | Sets the IRQ flag |
| pollBusy | input | 1 | Automatic controller polling in progress |
| version | input | 4 | Chip version code |
| pad2Data | input | 2 | Controller port 2 serial data |
| latchPulse | output | 1 | One-cycle counter-latch request |

## Verification
The bench aims at the edges of the horizontal blanking window at 2, 3, 1095 and 1096. A design with a misplaced comparison or an unwrapped window would report blanking one count too early or too late. It reads each interrupt flag twice in a row and also reads it in the same cycle as a set event. A design that clears without priority would lose an event, and one that never clears would show a stale flag. It tracks the open-bus byte through mixed reads and writes. A design that skipped updating on reads, or took the raw input instead of the returned byte, would corrupt the filler bits. Write sequences 0x80 then 0x00 then 0x00 check that `latchPulse` fires only on a true falling edge.

// File: rtl/video_status_pkg.sv
package video_status_pkg;
  typedef enum logic [2:0] {
    SEL_BUS, SEL_NMI, SEL_IRQ, SEL_BLANK, SEL_IO, SEL_PAD2
  } readSel_e;

  typedef struct packed {
    logic     busRd;
    logic     busWr;
    logic     clrNmi;
    logic     clrIrq;
    logic     ioWr;
    readSel_e sel;
  } strobe_t;
endpackage

// File: rtl/video_status_ctrl.sv
module video_status_ctrl
  import video_status_pkg::*;
#(
  parameter logic [15:0] ADDR_NMI   = 16'h4210,
  parameter logic [15:0] ADDR_IRQ   = 16'h4211,
  parameter logic [15:0] ADDR_BLANK = 16'h4212,
  parameter logic [15:0] ADDR_IORD  = 16'h4213,
  parameter logic [15:0] ADDR_IOWR  = 16'h4201,
  parameter logic [15:0] ADDR_PAD2  = 16'h4017
) (
  input  logic [15:0] addr,
  input  logic        rdEn,
  input  logic        wrEn,
  output strobe_t     stb
);
  logic readOnly;

  always_comb begin
    readOnly   = rdEn && !wrEn;
    stb        = '0;
    stb.busWr  = wrEn;
    stb.busRd  = readOnly;
    stb.clrNmi = readOnly && (addr == ADDR_NMI);
    stb.clrIrq = readOnly && (addr == ADDR_IRQ);
    stb.ioWr   = wrEn && (addr == ADDR_IOWR);
    case (addr)
      ADDR_NMI:   stb.sel = SEL_NMI;
      ADDR_IRQ:   stb.sel = SEL_IRQ;
      ADDR_BLANK: stb.sel = SEL_BLANK;
      ADDR_IORD:  stb.sel = SEL_IO;
      ADDR_PAD2:  stb.sel = SEL_PAD2;
      default:    stb.sel = SEL_BUS;
    endcase
  end
endmodule

// File: rtl/video_status_dp.sv
module video_status_dp
  import video_status_pkg::*;
#(
  parameter int HCNT_W    = 11,
  parameter int VCNT_W    = 9,
  parameter int HBLANK_LO = 2,
  parameter int HBLANK_HI = 1096
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        wrData,
  input  logic [HCNT_W-1:0] hCount,
  input  logic [VCNT_W-1:0] vCount,
  input  logic [VCNT_W-1:0] activeLines,
  input  logic              nmiEvent,
  input  logic              irqEvent,
  input  logic              pollBusy,
  input  logic [3:0]        version,
  input  logic [1:0]        pad2Data,
  output logic [7:0]        rdValue,
  output logic              latchPulse
);
  localparam logic [HCNT_W-1:0] H_LO = HCNT_W'(HBLANK_LO);
  localparam logic [HCNT_W-1:0] H_HI = HCNT_W'(HBLANK_HI);

  logic [7:0] openBus;
  logic [7:0] ioPort;
  logic       nmiFlag;
  logic       irqFlag;
  logic       hBlank;
  logic       vBlank;

  always_comb begin
    hBlank = (hCount <= H_LO) || (hCount >= H_HI);
    vBlank = (vCount >= activeLines);
    case (stb.sel)
      SEL_NMI:   rdValue = {nmiFlag, openBus[6:4], version};
      SEL_IRQ:   rdValue = {irqFlag, openBus[6:0]};
      SEL_BLANK: rdValue = {vBlank, hBlank, openBus[5:1], pollBusy};
      SEL_IO:    rdValue = ioPort;
      SEL_PAD2:  rdValue = {openBus[7:5], 3'b111, pad2Data};
      default:   rdValue = openBus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openBus    <= 8'h00;
      ioPort     <= 8'hFF;
      nmiFlag    <= 1'b0;
      irqFlag    <= 1'b0;
      latchPulse <= 1'b0;
    end else begin
      if (stb.busWr)      openBus <= wrData;
      else if (stb.busRd) openBus <= rdValue;

      if (nmiEvent)        nmiFlag <= 1'b1;
      else if (stb.clrNmi) nmiFlag <= 1'b0;

      if (irqEvent)        irqFlag <= 1'b1;
      else if (stb.clrIrq) irqFlag <= 1'b0;

      if (stb.ioWr) ioPort <= wrData;
      latchPulse <= stb.ioWr && ioPort[7] && !wrData[7];
    end
  end
endmodule

// File: rtl/video_status_regs.sv
module video_status_regs
  import video_status_pkg::*;
#(
  parameter int HCNT_W    = 11,
  parameter int VCNT_W    = 9,
  parameter int HBLANK_LO = 2,
  parameter int HBLANK_HI = 1096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [HCNT_W-1:0] hCount,
  input  logic [VCNT_W-1:0] vCount,
  input  logic [VCNT_W-1:0] activeLines,
  input  logic              nmiEvent,
  input  logic              irqEvent,
  input  logic              pollBusy,
  input  logic [3:0]        version,
  input  logic [1:0]        pad2Data,
  output logic              latchPulse
);
  strobe_t stb;

  video_status_ctrl u_ctrl (
    .addr (addr),
    .rdEn (rdEn),
    .wrEn (wrEn),
    .stb  (stb)
  );

  video_status_dp #(
    .HCNT_W    (HCNT_W),
    .VCNT_W    (VCNT_W),
    .HBLANK_LO (HBLANK_LO),
    .HBLANK_HI (HBLANK_HI)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .hCount      (hCount),
    .vCount      (vCount),
    .activeLines (activeLines),
    .nmiEvent    (nmiEvent),
    .irqEvent    (irqEvent),
    .pollBusy    (pollBusy),
    .version     (version),
    .pad2Data    (pad2Data),
    .rdValue     (rdData),
    .latchPulse  (latchPulse)
  );
endmodule

// File: rtl/video_status_checker.sv
module video_status_checker #(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic [VCNT_W-1:0] vCount,
  input logic [VCNT_W-1:0] activeLines,
  input logic              nmiEvent,
  input logic [3:0]        version,
  input logic [1:0]        pad2Data,
  input logic              latchPulse
);
  logic nmiRd, plainRd, unmapped;
  assign nmiRd    = rdEn && !wrEn && addr == 16'h4210;
  assign plainRd  = rdEn && !wrEn;
  assign unmapped = addr != 16'h4210 && addr != 16'h4211 && addr != 16'h4212 &&
                    addr != 16'h4213 && addr != 16'h4017;

  assert_version_field_R1: assert property (@(posedge clk) disable iff (!rstN)
    nmiRd |-> rdData[3:0] == version);

  assert_nmi_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    (nmiRd && !nmiEvent) ##1 nmiRd |-> !rdData[7]);

  assert_vblank_R4: assert property (@(posedge clk) disable iff (!rstN)
    (plainRd && addr == 16'h4212) |-> rdData[7] == (vCount >= activeLines));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    latchPulse |=> !latchPulse);

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    latchPulse |-> ($past(wrEn) && $past(addr) == 16'h4201 && !$past(wrData[7])));

  assert_pad2_format_R9: assert property (@(posedge clk) disable iff (!rstN)
    (plainRd && addr == 16'h4017) |-> (rdData[4:2] == 3'b111 && rdData[1:0] == pad2Data));

  assert_open_bus_R10: assert property (@(posedge clk) disable iff (!rstN)
    (plainRd && unmapped && $past(rstN) && $past(wrEn)) |-> rdData == $past(wrData));
endmodule

bind video_status_regs video_status_checker #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_chk (
  .clk (clk), .rstN (rstN), .addr (addr), .rdEn (rdEn), .wrEn (wrEn),
  .wrData (wrData), .rdData (rdData), .vCount (vCount), .activeLines (activeLines),
  .nmiEvent (nmiEvent), .version (version), .pad2Data (pad2Data),
  .latchPulse (latchPulse)
);

// File: tb/sim_video_status_regs.sv
`timescale 1ns/1ps
module sim_video_status_regs;
  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] addr = 0;
  logic        rdEn = 0, wrEn = 0;
  logic [7:0]  wrData = 0;
  logic [7:0]  rdData;
  logic [10:0] hCount = 0;
  logic [8:0]  vCount = 0, activeLines = 9'd224;
  logic        nmiEvent = 0, irqEvent = 0, pollBusy = 0;
  logic [3:0]  version = 4'h2;
  logic [1:0]  pad2Data = 0;
  logic        latchPulse;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] busM = 8'h00, ioM = 8'hFF;
  bit nmiM = 0, irqM = 0;

  always #5 clk = ~clk;

  video_status_regs u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .hCount(hCount), .vCount(vCount),
    .activeLines(activeLines), .nmiEvent(nmiEvent), .irqEvent(irqEvent),
    .pollBusy(pollBusy), .version(version), .pad2Data(pad2Data),
    .latchPulse(latchPulse)
  );

  function automatic logic [7:0] expRead(input logic [15:0] a);
    bit hb, vb;
    hb = (hCount <= 11'd2) || (hCount >= 11'd1096);
    vb = (vCount >= activeLines);
    case (a)
      16'h4210: return {nmiM, busM[6:4], version};
      16'h4211: return {irqM, busM[6:0]};
      16'h4212: return {vb, hb, busM[5:1], pollBusy};
      16'h4213: return ioM;
      16'h4017: return {busM[7:5], 3'b111, pad2Data};
      default:  return busM;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit rd, input bit wr, input logic [15:0] a,
                    input logic [7:0] d, input bit nEv, input bit iEv, input string req);
    logic [7:0] e;
    bit expPulse;
    @(negedge clk);
    addr = a; rdEn = rd; wrEn = wr; wrData = d; nmiEvent = nEv; irqEvent = iEv;
    #1;
    e = expRead(a);
    if (rd && !wr) check(req, rdData, e);
    expPulse = wr && a == 16'h4201 && ioM[7] && !d[7];
    if (wr) begin
      busM = d;
      if (a == 16'h4201) ioM = d;
    end else if (rd) busM = e;
    if (nEv) nmiM = 1; else if (rd && !wr && a == 16'h4210) nmiM = 0;
    if (iEv) irqM = 1; else if (rd && !wr && a == 16'h4211) irqM = 0;
    @(posedge clk); #1;
    rdEn = 0; wrEn = 0; nmiEvent = 0; irqEvent = 0;
    check("R8 latchPulse", {7'd0, latchPulse}, {7'd0, expPulse});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd77);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R11 reset state
    check("R11 latchPulse after reset", {7'd0, latchPulse}, 8'd0);
    op(1, 0, 16'h1234, 0, 0, 0, "R11 open bus reset");
    op(1, 0, 16'h4210, 0, 0, 0, "R11 nmi clear at reset");
    op(1, 0, 16'h4213, 0, 0, 0, "R7 io reset value");
    // R5 horizontal window edges
    hCount = 11'd2;    op(1, 0, 16'h4212, 0, 0, 0, "R5 hcount 2");
    hCount = 11'd3;    op(1, 0, 16'h4212, 0, 0, 0, "R5 hcount 3");
    hCount = 11'd1095; op(1, 0, 16'h4212, 0, 0, 0, "R5 hcount 1095");
    hCount = 11'd1096; op(1, 0, 16'h4212, 0, 0, 0, "R5 hcount 1096");
    // R4 vertical edges, R6 poll
    vCount = 9'd223; pollBusy = 1; op(1, 0, 16'h4212, 0, 0, 0, "R4 R6 below active");
    vCount = 9'd224; pollBusy = 0; op(1, 0, 16'h4212, 0, 0, 0, "R4 at active count");
    // R2 set, read, read again; same-cycle set wins
    op(0, 0, 16'h0, 0, 1, 0, "R2 set");
    op(1, 0, 16'h4210, 0, 0, 0, "R2 read set flag");
    op(1, 0, 16'h4210, 0, 0, 0, "R2 flag cleared");
    op(1, 0, 16'h4210, 0, 1, 0, "R2 read with set same cycle");
    op(1, 0, 16'h4210, 0, 0, 0, "R2 flag kept by set priority");
    // R3
    op(0, 0, 16'h0, 0, 0, 1, "R3 set");
    op(0, 1, 16'h2000, 8'h5A, 0, 0, "R10 write bus");
    op(1, 0, 16'h4211, 0, 0, 0, "R3 read set flag");
    op(1, 0, 16'h4211, 0, 0, 0, "R3 flag cleared");
    // R8 / R7 latch sequence
    op(0, 1, 16'h4201, 8'h80, 0, 0, "R8 write 80");
    op(0, 1, 16'h4201, 8'h00, 0, 0, "R8 falling edge");
    op(0, 1, 16'h4201, 8'h00, 0, 0, "R8 no edge");
    op(1, 0, 16'h4213, 0, 0, 0, "R7 readback");
    // R9, R10 with both strobes
    pad2Data = 2'b10;
    op(0, 1, 16'h3000, 8'hA5, 0, 0, "R10 write");
    op(1, 0, 16'h4017, 0, 0, 0, "R9 pad2 read");
    op(1, 1, 16'h4213, 8'h3C, 0, 0, "R10 both strobes");
    op(1, 0, 16'h7777, 0, 0, 0, "R10 open bus after dual");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [15:0] a;
      hCount = 11'($urandom_range(0, 1363));
      vCount = 9'($urandom_range(0, 261));
      activeLines = ($urandom_range(0, 1) == 1) ? 9'd224 : 9'd239;
      pollBusy = 1'($urandom);
      version = 4'($urandom);
      pad2Data = 2'($urandom);
      kind = $urandom_range(0, 9);
      case ($urandom_range(0, 6))
        0: a = 16'h4210;
        1: a = 16'h4211;
        2: a = 16'h4212;
        3: a = 16'h4213;
        4: a = 16'h4017;
        5: a = 16'h4201;
        default: a = 16'($urandom);
      endcase
      if (kind < 5)      op(1, 0, a, 0, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0), "R1 R3 R4 R5 R6 R7 R9 R10 random read");
      else if (kind < 8) op(0, 1, a, 8'($urandom), 0, 0, "R10 random write");
      else               op(0, 0, a, 0, 1'($urandom), 1'($urandom), "R2 R3 random event");
    end
    summary();
  end
endmodule